// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block drives a 10-bit successive-approximation converter that has a three-wire serial port: an active-low chip select, an I/O clock and a data line back to the host. On each accepted start request it pulls chip select low and produces exactly ten I/O clock pulses from the system clock. It shifts in the returned bits, most significant first. It then releases chip select for the whole conversion interval and waits out the conversion time before it accepts another request.

The converter returns the result of the conversion started by the *previous* transfer. For this reason the controller runs one priming transfer on its own after reset. It discards that data and waits a full conversion interval, so every word it later presents belongs to a known conversion. Each result comes with a one-cycle `result_valid` pulse. The `busy` output tells the host when a new start will be taken.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `adc_cs_n` is 1, `adc_ioclk` is 0, `busy` is 1 and `result_valid` is 0.
- R2: After reset, without any `start`, the block performs one complete transfer followed by a conversion wait. It produces no `result_valid` pulse for that transfer, and `busy` stays 1 until that wait has ended.
- R3: Every transfer holds `adc_cs_n` low and produces exactly `NBITS` (10) rising edges of `adc_ioclk`. `adc_ioclk` is 0 whenever `adc_cs_n` is 1.
- R4: The first rising edge of `adc_ioclk` comes `HALF_CYC` system cycles after `adc_cs_n` falls. Each high phase and each low phase of `adc_ioclk` lasts `HALF_CYC` cycles, and `adc_cs_n` rises `HALF_CYC` cycles after the last falling edge.
- R5: `adc_dout` is sampled at each rising edge of `adc_ioclk`. The first sample is stored as bit `NBITS-1` (MSB) of `result` and the last as bit 0.
- R6: After a transfer, `adc_cs_n` stays high for at least `CONV_CYC` system cycles before it falls again, and `busy` stays 1 throughout that wait.
- R7: `result_valid` is high for exactly one cycle per non-priming transfer, asserted while `adc_cs_n` is high. `result` changes only in the cycle that `result_valid` is asserted.
- R8: `start` is acted on only when `busy` is 0. A `start` while `busy` is 1, whether during a transfer or during the conversion wait, causes no additional transfer.
- R9: The word presented after transfer k equals the value the converter latched at the tenth falling `adc_ioclk` edge of transfer k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one transfer; taken only when `busy` is 0 |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_ioclk | output | 1 | I/O clock to the converter |
| busy | output | 1 | High while priming, transferring or waiting for conversion |
| result_valid | output | 1 | One-cycle pulse marking a new `result` |
| result | output | NBITS | Last received conversion word |

## Verification
The bench builds the block with `HALF_CYC` = 2 and `CONV_CYC` = 20. This keeps a full transfer plus its wait to roughly seventy cycles, so every one of the 1024 possible 10-bit codes can be carried through the behavioural converter model in a single run. It uses an odd-stride code sequence so that each code's expected value can be computed from the transfer index. At these values, extra start requests can be injected both mid-transfer and during the conversion wait, and every phase length can be measured against its exact expected cycle count.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,   // chip select low, clock low, before first pulse
        ST_HIGH  = 3'd2,   // I/O clock high phase
        ST_LOW   = 3'd3,   // I/O clock low phase
        ST_CONV  = 3'd4    // chip select released, conversion running
    } rd_state_e;

    // Pin levels derived from the sequencing state
    typedef struct packed {
        logic cs_n;
        logic ioclk;
    } pin_lvl_t;

    // Per-cycle control strobes produced by the sequencer
    typedef struct packed {
        logic clear;    // new transfer: empty the shifter
        logic sample;   // take one bit from the data line
        logic finish;   // last low phase ended
        logic restart;  // phase timer restarts
    } rd_ctl_t;

    function automatic pin_lvl_t pins_of(rd_state_e s);
        pin_lvl_t p;
        p.cs_n  = (s == ST_IDLE) || (s == ST_CONV);
        p.ioclk = (s == ST_HIGH);
        return p;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_for(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    assign expire = (cnt_q == (limit - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int unsigned NBITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             din,
    output logic [NBITS-1:0] word
);
    logic [NBITS-1:0] sh_q;

    generate
        if (NBITS == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst || clear)  sh_q <= '0;
                else if (shift_en) sh_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst || clear)  sh_q <= '0;
                else if (shift_en) sh_q <= {sh_q[NBITS-2:0], din};
            end
        end
    endgenerate

    assign word = sh_q;
endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
    import adc_rd_pkg::*;
#(
    parameter int unsigned NBITS = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      expire,
    output rd_state_e state,
    output rd_ctl_t   ctl,
    output logic      primed,
    output logic      busy
);
    localparam int unsigned BC_W = width_for(NBITS);

    rd_state_e     st_q, st_d;
    logic [BC_W-1:0] bcnt_q;
    logic          primed_q;
    rd_ctl_t       c;

    always_comb begin
        st_d     = st_q;
        c        = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (start || !primed_q) begin
                    st_d    = ST_LEAD;
                    c.clear = 1'b1;
                end
            end
            ST_LEAD: begin
                if (expire) begin
                    st_d     = ST_HIGH;
                    c.sample = 1'b1;
                end
            end
            ST_HIGH: begin
                if (expire) st_d = ST_LOW;
            end
            ST_LOW: begin
                if (expire) begin
                    if (bcnt_q == BC_W'(NBITS)) begin
                        st_d     = ST_CONV;
                        c.finish = 1'b1;
                    end else begin
                        st_d     = ST_HIGH;
                        c.sample = 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (expire) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
        c.restart = (st_d != st_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            bcnt_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (c.clear) begin
                bcnt_q <= '0;
            end else if (st_q == ST_HIGH && expire) begin
                bcnt_q <= bcnt_q + 1'b1;
            end
            if (st_q == ST_CONV && expire) begin
                primed_q <= 1'b1;
            end
        end
    end

    assign state  = st_q;
    assign ctl    = c;
    assign primed = primed_q;
    assign busy   = (st_q != ST_IDLE) || !primed_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int unsigned NBITS    = 10,
    parameter int unsigned HALF_CYC = 25,
    parameter int unsigned CONV_CYC = 2100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adc_dout,
    output logic             adc_cs_n,
    output logic             adc_ioclk,
    output logic             busy,
    output logic             result_valid,
    output logic [NBITS-1:0] result
);
    localparam int unsigned LIM_W = width_for(max_u(HALF_CYC, CONV_CYC));
    localparam logic [LIM_W-1:0] HALF_LIM = LIM_W'(HALF_CYC);
    localparam logic [LIM_W-1:0] CONV_LIM = LIM_W'(CONV_CYC);

    rd_state_e        state;
    rd_ctl_t          ctl;
    pin_lvl_t         pins;
    logic             primed;
    logic             expire;
    logic [LIM_W-1:0] limit;
    logic [NBITS-1:0] word;
    logic             valid_q;
    logic [NBITS-1:0] result_q;

    adc_rd_fsm #(.NBITS(NBITS)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .expire (expire),
        .state  (state),
        .ctl    (ctl),
        .primed (primed),
        .busy   (busy)
    );

    assign limit = (state == ST_CONV) ? CONV_LIM : HALF_LIM;

    adc_rd_timer #(.W(LIM_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (ctl.restart),
        .limit   (limit),
        .expire  (expire)
    );

    adc_rd_shift #(.NBITS(NBITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (ctl.clear),
        .shift_en (ctl.sample),
        .din      (adc_dout),
        .word     (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            valid_q <= ctl.finish && primed;
            if (ctl.finish && primed) begin
                result_q <= word;
            end
        end
    end

    assign pins         = pins_of(state);
    assign adc_cs_n     = pins.cs_n;
    assign adc_ioclk    = pins.ioclk;
    assign result_valid = valid_q;
    assign result       = result_q;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
    parameter int unsigned NBITS    = 10,
    parameter int unsigned HALF_CYC = 25,
    parameter int unsigned CONV_CYC = 2100
) (
    input logic             clk,
    input logic             rst,
    input logic             adc_cs_n,
    input logic             adc_ioclk,
    input logic             busy,
    input logic             result_valid,
    input logic [NBITS-1:0] result
);
    localparam int unsigned RC_W = $clog2(NBITS + 2);
    localparam int unsigned HC_W = $clog2(CONV_CYC + 2);

    logic            prev_cs_q, prev_io_q;
    logic [RC_W-1:0] rise_cnt_q;
    logic [HC_W-1:0] hi_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cs_q  <= 1'b1;
            prev_io_q  <= 1'b0;
            rise_cnt_q <= '0;
            hi_cnt_q   <= HC_W'(CONV_CYC);
        end else begin
            prev_cs_q <= adc_cs_n;
            prev_io_q <= adc_ioclk;
            if (!adc_cs_n && prev_cs_q)           rise_cnt_q <= '0;
            else if (adc_ioclk && !prev_io_q)     rise_cnt_q <= rise_cnt_q + 1'b1;
            if (adc_cs_n && !prev_cs_q)           hi_cnt_q <= HC_W'(1);
            else if (adc_cs_n && hi_cnt_q < HC_W'(CONV_CYC)) hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> adc_cs_n && !adc_ioclk && busy && !result_valid);

    p_clk_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> !adc_ioclk);

    p_ten_pulses_r3: assert property (@(posedge clk) disable iff (rst)
        (adc_cs_n && !prev_cs_q) |-> (rise_cnt_q == RC_W'(NBITS)));

    p_conv_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (!adc_cs_n && prev_cs_q) |-> (hi_cnt_q >= HC_W'(CONV_CYC)));

    p_busy_in_xfer_r8: assert property (@(posedge clk) disable iff (rst)
        !adc_cs_n |-> busy);

    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    p_valid_cs_high_r7: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> adc_cs_n && busy);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .NBITS    (NBITS),
    .HALF_CYC (HALF_CYC),
    .CONV_CYC (CONV_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .adc_cs_n     (adc_cs_n),
    .adc_ioclk    (adc_ioclk),
    .busy         (busy),
    .result_valid (result_valid),
    .result       (result)
);

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;
    localparam int NB   = 10;
    localparam int HALF = 2;
    localparam int CONV = 20;
    localparam int NCODES = 1 << NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          adc_dout = 1'b0;
    logic          adc_cs_n, adc_ioclk, busy, result_valid;
    logic [NB-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    adc_rd_ctrl #(.NBITS(NB), .HALF_CYC(HALF), .CONV_CYC(CONV)) u_dut (
        .clk(clk), .rst(rst), .start(start), .adc_dout(adc_dout),
        .adc_cs_n(adc_cs_n), .adc_ioclk(adc_ioclk), .busy(busy),
        .result_valid(result_valid), .result(result)
    );

    function automatic logic [NB-1:0] code_at(int j);
        return NB'((j * 37 + 5) % NCODES);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural converter: returns the previous conversion, MSB first
    logic [NB-1:0] conv_word = 10'h2A5;
    int  falls = 0, rises = 0, xfers = 0, conv_idx = 0;
    bit  in_xfer = 1'b0;

    always @(negedge adc_cs_n) begin
        in_xfer  = 1'b1;
        falls    = 0;
        rises    = 0;
        xfers++;
        adc_dout <= conv_word[NB-1];
    end
    always @(posedge adc_ioclk) if (in_xfer) rises++;
    always @(negedge adc_ioclk) begin
        if (in_xfer) begin
            falls++;
            if (falls < NB) begin
                adc_dout <= conv_word[NB-1-falls];
            end else if (falls == NB) begin
                conv_word = code_at(conv_idx);
                conv_idx++;
                adc_dout <= 1'b0;
            end
        end
    end
    always @(posedge adc_cs_n) begin
        if (in_xfer) begin
            in_xfer = 1'b0;
            check(rises == NB, "R3 pulses per transfer", rises, NB);
        end
    end

    // Phase-length and valid-pulse monitor, sampled away from the active edge
    int       n_valid = 0;
    bit       prev_valid = 1'b0;
    logic [1:0] prev_pins = 2'b10;
    int       run = 0;
    bit       seen_rise = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            prev_pins  = 2'b10;
            run        = 0;
            seen_rise  = 1'b0;
            prev_valid = 1'b0;
        end else begin
            if (result_valid) begin
                n_valid++;
                check(!prev_valid, "R7 single-cycle valid", 1, 0);
                check(adc_cs_n == 1'b1, "R7 valid with cs high", int'(adc_cs_n), 1);
            end
            prev_valid = result_valid;
            if ({adc_cs_n, adc_ioclk} != prev_pins) begin
                if (prev_pins[1] == 1'b0) begin
                    check(run == HALF, "R4 phase length", run, HALF);
                end else if (seen_rise) begin
                    check(run >= CONV, "R6 cs high gap", run, CONV);
                end
                if (adc_cs_n && !prev_pins[1]) seen_rise = 1'b1;
                check(!(adc_cs_n && adc_ioclk), "R3 clock low when deselected", 1, 0);
                prev_pins = {adc_cs_n, adc_ioclk};
                run = 1;
            end else begin
                run++;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        // R1: reset state
        check(adc_cs_n == 1'b1, "R1 cs_n in reset", int'(adc_cs_n), 1);
        check(adc_ioclk == 1'b0, "R1 ioclk in reset", int'(adc_ioclk), 0);
        check(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
        check(result_valid == 1'b0, "R1 valid in reset", int'(result_valid), 0);
        rst = 1'b0;

        // R2: priming transfer runs alone, no valid, busy until its wait ends
        @(negedge clk);
        while (adc_cs_n) begin
            check(busy == 1'b1, "R2 busy before priming", int'(busy), 1);
            @(negedge clk);
        end
        while (busy) @(negedge clk);
        check(xfers == 1, "R2 one priming transfer", xfers, 1);
        check(n_valid == 0, "R2 no valid while priming", n_valid, 0);
        check(result == '0, "R2 result untouched", int'(result), 0);
        repeat (6) @(negedge clk);
        check(adc_cs_n == 1'b1, "R8 idle without start", int'(adc_cs_n), 1);
        check(xfers == 1, "R8 no transfer without start", xfers, 1);

        // Exhaustive code sweep: R5, R9, plus busy-start cases for R8
        for (int k = 1; k <= NCODES; k++) begin
            while (busy) @(negedge clk);
            pulse_start();
            if (k % 4 == 0) begin
                while (adc_cs_n) @(negedge clk);
                pulse_start();
            end
            while (!result_valid) @(negedge clk);
            check(result == code_at(k - 1), "R9 R5 returned word",
                  int'(result), int'(code_at(k - 1)));
            check(busy == 1'b1, "R6 busy during conversion", int'(busy), 1);
            @(negedge clk);
            check(result == code_at(k - 1), "R7 result held", int'(result),
                  int'(code_at(k - 1)));
            check(n_valid == k, "R8 valid count", n_valid, k);
            check(xfers == k + 1, "R8 transfer count", xfers, k + 1);
            if (k % 64 == 0) begin
                start = 1'b1;
                @(negedge clk) start = 1'b0;
                while (busy) @(negedge clk);
                repeat (4) @(negedge clk);
                check(adc_cs_n == 1'b1, "R8 start in conversion ignored", int'(adc_cs_n), 1);
                check(xfers == k + 1, "R8 no extra transfer", xfers, k + 1);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule